// File: doc/BRIEF.md
# Cascade Initialization Sequencer

This block brings a chain of 1 to 16 cascaded prefix-lookup devices into a known state after power-up. Once its own reset is released, it holds a reset line to the lookup controller for a fixed number of cycles. It then waits one idle cycle and issues a fixed series of commands to the command decoder over a valid/ready handshake. Each device in the chain is given a unique identifier, starting at zero. Between two identifier writes, a set-full command marks the device just numbered as full, so that the next identifier write lands on the following device. A software-reset command closes the series. After one more idle cycle the block raises `done`, and `done` stays high until the next reset.

The number of devices comes in on the `dev_count` input. Out-of-range values are clamped to the supported range. The count is captured once, during the idle cycle, so a later change to the input has no effect on a sequence that is already running.

Every state and transition of the state machine has a name:

- **ST_HOLD** drives the reset output. It moves to ST_GAP when the hold timer expires.
- **ST_GAP** is the idle cycle. It captures the clamped count and clears the identifier, then always moves to ST_WR_ID.
- **ST_WR_ID** issues an identifier write. When the command is accepted, it moves to ST_SW_RST if the identifier equals the last one, and to ST_SET_FULL otherwise.
- **ST_SET_FULL** issues a set-full command. When the command is accepted, it increments the identifier and returns to ST_WR_ID.
- **ST_SW_RST** issues the software reset. When the command is accepted, it moves to ST_SETTLE.
- **ST_SETTLE** is the final idle cycle. It always moves to ST_DONE.
- **ST_DONE** is terminal. It is left only through `rst_n`.

Top module: `casc_init_seq`

## Requirements
- R1: While `rst_n` is low, `ctrl_rst_out` is 1, `cmd_valid` is 0 and `done` is 0.
- R2: After `rst_n` rises, `ctrl_rst_out` stays high for exactly HOLD_CYCLES (64) clock cycles.
- R3: Exactly one cycle passes after `ctrl_rst_out` falls in which there is neither a command nor `done`, before the first command is offered.
- R4: The first command has opcode 0xA (identifier write), with identifier 0 in the low bits of `cmd_data` and all other bits zero.
- R5: For N devices with N > 1, each identifier write k (for k = 1 to N-1) is preceded by a set-full command with opcode 0x9 and zero data. The identifiers increase by one per write, and the last one is N-1.
- R6: With one device, the identifier write of 0 is followed directly by the software reset.
- R7: The last command is a software reset with opcode 0xB and zero data. After it is accepted, exactly one cycle passes with neither a command nor `done`, and then `done` rises.
- R8: Once `done` is high, it stays high and no further command is offered until `rst_n` falls.
- R9: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_op` and `cmd_data` hold their values. The sequence advances only on a cycle in which both `cmd_valid` and `cmd_ready` are high.
- R10: A `dev_count` of 0 behaves as 1, and a value above MAX_DEVS (16) behaves as 16.
- R11: `dev_count` is captured in the idle cycle of R3. Changing it afterwards does not alter the commands issued.
- R12: Lowering `rst_n` in the middle of a sequence abandons it, and the full sequence restarts from the reset hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| dev_count | input | 5 | Number of devices in the cascade (clamped) |
| cmd_ready | input | 1 | Command decoder accepts the offered command |
| ctrl_rst_out | output | 1 | Active-high reset to the lookup controller |
| cmd_valid | output | 1 | A command is offered |
| cmd_op | output | 4 | Opcode of the offered command |
| cmd_data | output | 40 | Data of the offered command (identifier in the low bits) |
| done | output | 1 | Initialization complete |

## Verification
The bench uses the default parameters: MAX_DEVS of 16, HOLD_CYCLES of 64 and a 40-bit data field. With these values both ends of the loop can be reached in a single build: a lone device, where the loop is skipped, and a full chain of 16 devices, which reaches the widest identifier. The count values 0, 20 and 31 drive the clamp on both sides. Different readiness patterns on `cmd_ready` stall commands at every position in the series, and a reset in mid-sequence together with a count change after capture covers the restart and the ignored-input cases.

// File: rtl/casc_init_pkg.sv
package casc_init_pkg;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_GAP,
        ST_WR_ID,
        ST_SET_FULL,
        ST_SW_RST,
        ST_SETTLE,
        ST_DONE
    } seq_state_t;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_NONE     = 4'h0;
    localparam logic [OP_W-1:0] OP_SET_FULL = 4'h9;
    localparam logic [OP_W-1:0] OP_WR_ID    = 4'hA;
    localparam logic [OP_W-1:0] OP_SW_RST   = 4'hB;

endpackage

// File: rtl/casc_rst_timer.sv
module casc_rst_timer #(
    parameter int HOLD_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    assign expire = run && (cnt == CW'(HOLD_CYCLES - 1));

endmodule

// File: rtl/casc_count_clamp.sv
module casc_count_clamp #(
    parameter int MAX_DEVS = 16,
    parameter int IN_W     = 5,
    parameter int ID_W     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [IN_W-1:0] dev_count,
    output logic [ID_W-1:0] last_id
);
    logic [ID_W-1:0] last_nxt;

    always_comb begin
        if (dev_count == '0) begin
            last_nxt = '0;
        end else if (int'(dev_count) > MAX_DEVS) begin
            last_nxt = ID_W'(MAX_DEVS - 1);
        end else begin
            last_nxt = ID_W'(dev_count - 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_id <= '0;
        end else if (capture) begin
            last_id <= last_nxt;
        end
    end

endmodule

// File: rtl/casc_cmd_drive.sv
module casc_cmd_drive
    import casc_init_pkg::*;
#(
    parameter int DATA_W = 40,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state,
    input  logic              id_clear,
    input  logic              id_step,
    output logic [ID_W-1:0]   cur_id,
    output logic              cmd_valid,
    output logic [OP_W-1:0]   cmd_op,
    output logic [DATA_W-1:0] cmd_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_id <= '0;
        end else if (id_clear) begin
            cur_id <= '0;
        end else if (id_step) begin
            cur_id <= cur_id + 1'b1;
        end
    end

    always_comb begin
        cmd_valid = 1'b0;
        cmd_op    = OP_NONE;
        cmd_data  = '0;
        unique case (state)
            ST_WR_ID: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_WR_ID;
                cmd_data  = DATA_W'(cur_id);
            end
            ST_SET_FULL: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_SET_FULL;
            end
            ST_SW_RST: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_SW_RST;
            end
            ST_HOLD, ST_GAP, ST_SETTLE, ST_DONE: begin
                cmd_valid = 1'b0;
            end
            default: begin
                cmd_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/casc_init_seq.sv
module casc_init_seq
    import casc_init_pkg::*;
#(
    parameter int MAX_DEVS    = 16,
    parameter int HOLD_CYCLES = 64,
    parameter int DATA_W      = 40
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(MAX_DEVS+1)-1:0] dev_count,
    input  logic                          cmd_ready,
    output logic                          ctrl_rst_out,
    output logic                          cmd_valid,
    output logic [3:0]                    cmd_op,
    output logic [DATA_W-1:0]             cmd_data,
    output logic                          done
);
    localparam int IN_W = $clog2(MAX_DEVS + 1);
    localparam int ID_W = (MAX_DEVS > 1) ? $clog2(MAX_DEVS) : 1;

    seq_state_t      state, state_nxt;
    logic            hold_expire;
    logic            accept;
    logic [ID_W-1:0] last_id;
    logic [ID_W-1:0] cur_id;

    assign accept = cmd_valid && cmd_ready;

    casc_rst_timer #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_HOLD),
        .expire (hold_expire)
    );

    casc_count_clamp #(
        .MAX_DEVS(MAX_DEVS),
        .IN_W    (IN_W),
        .ID_W    (ID_W)
    ) u_clamp (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (state == ST_GAP),
        .dev_count (dev_count),
        .last_id   (last_id)
    );

    casc_cmd_drive #(
        .DATA_W(DATA_W),
        .ID_W  (ID_W)
    ) u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .id_clear  (state == ST_GAP),
        .id_step   ((state == ST_SET_FULL) && accept),
        .cur_id    (cur_id),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_data  (cmd_data)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HOLD:     if (hold_expire) state_nxt = ST_GAP;
            ST_GAP:      state_nxt = ST_WR_ID;
            ST_WR_ID:    if (accept) state_nxt = (cur_id == last_id) ? ST_SW_RST : ST_SET_FULL;
            ST_SET_FULL: if (accept) state_nxt = ST_WR_ID;
            ST_SW_RST:   if (accept) state_nxt = ST_SETTLE;
            ST_SETTLE:   state_nxt = ST_DONE;
            ST_DONE:     state_nxt = ST_DONE;
            default:     state_nxt = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HOLD;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        ctrl_rst_out = (state == ST_HOLD);
        done         = (state == ST_DONE);
    end

endmodule

// File: rtl/casc_init_chk.sv
module casc_init_chk #(
    parameter int HOLD_CYCLES = 64,
    parameter int DATA_W      = 40,
    parameter int MAX_DEVS    = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              ctrl_rst_out,
    input logic              cmd_valid,
    input logic [3:0]        cmd_op,
    input logic [DATA_W-1:0] cmd_data,
    input logic              done
);
    localparam int HW = $clog2(HOLD_CYCLES + 2);

    logic [HW-1:0] hold_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_seen <= '0;
        end else if (ctrl_rst_out) begin
            hold_seen <= hold_seen + 1'b1;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) !rst_n |-> (ctrl_rst_out && !cmd_valid && !done));

    // R2
    hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rst_out |-> (int'(hold_seen) < HOLD_CYCLES));

    // R2
    hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_rst_out) |-> (int'(hold_seen) == HOLD_CYCLES));

    // R3
    gap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_rst_out) |-> (!cmd_valid && !done));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_data)));

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid);

    // R5
    op_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_op == 4'h9 || cmd_op == 4'hA || cmd_op == 4'hB));

    // R5
    id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'hA) |-> (cmd_data < DATA_W'(MAX_DEVS)));

endmodule

bind casc_init_seq casc_init_chk #(
    .HOLD_CYCLES(HOLD_CYCLES),
    .DATA_W     (DATA_W),
    .MAX_DEVS   (MAX_DEVS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_ready    (cmd_ready),
    .ctrl_rst_out (ctrl_rst_out),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_data     (cmd_data),
    .done         (done)
);

// File: tb/sim_casc_init_seq.sv
`timescale 1ns/1ps
module sim_casc_init_seq;

    localparam int MAX_DEVS = 16;
    localparam int HOLD     = 64;
    localparam int DW       = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    dev_count = 5'd1;
    logic          cmd_ready = 1'b1;
    logic          ctrl_rst_out, cmd_valid, done;
    logic [3:0]    cmd_op;
    logic [DW-1:0] cmd_data;

    int checks = 0;
    int errors = 0;

    logic [DW+3:0] exp_q[$];

    int   rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    int   rst_cnt, gap_cnt, settle_cnt, acc_cnt;
    logic seen_cmd, sw_seen, done_seen;
    logic prev_stall;
    logic [3:0]    prev_op;
    logic [DW-1:0] prev_data;

    always #5 clk = ~clk;

    casc_init_seq #(
        .MAX_DEVS   (MAX_DEVS),
        .HOLD_CYCLES(HOLD),
        .DATA_W     (DW)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .dev_count    (dev_count),
        .cmd_ready    (cmd_ready),
        .ctrl_rst_out (ctrl_rst_out),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_data     (cmd_data),
        .done         (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // readiness driver: changes 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (rdy_mode)
                0:       cmd_ready = 1'b1;
                1:       cmd_ready = lfsr[0];
                default: cmd_ready = (lfsr[1:0] == 2'b00);
            endcase
        end
    end

    // scoreboard driver: expected command list for a given count
    task automatic push_expected(input int n);
        int m;
        m = (n < 1) ? 1 : (n > MAX_DEVS ? MAX_DEVS : n);
        exp_q.delete();
        exp_q.push_back({4'hA, {DW{1'b0}}});
        for (int k = 1; k < m; k++) begin
            exp_q.push_back({4'h9, {DW{1'b0}}});
            exp_q.push_back({4'hA, DW'(k)});
        end
        exp_q.push_back({4'hB, {DW{1'b0}}});
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (!seen_cmd && ctrl_rst_out) rst_cnt++;
            if (!seen_cmd && !ctrl_rst_out && !cmd_valid && !done) gap_cnt++;
            if (prev_stall) begin
                check(cmd_valid && cmd_op == prev_op && cmd_data == prev_data,
                      "R9", "stalled command changed", {cmd_valid, cmd_op}, {1'b1, prev_op});
            end
            if (cmd_valid) begin
                seen_cmd = 1'b1;
                if (cmd_ready) begin
                    acc_cnt++;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R5 R6 R7", "unexpected command", cmd_op, 0);
                    end else begin
                        logic [DW+3:0] e;
                        e = exp_q.pop_front();
                        check({cmd_op, cmd_data} == e, "R4 R5 R6 R7", "command op/data",
                              longint'({cmd_op, cmd_data}), longint'(e));
                    end
                    if (cmd_op == 4'hB) sw_seen = 1'b1;
                end
            end
            if (sw_seen && !done && !cmd_valid) settle_cnt++;
            if (done) done_seen = 1'b1;
            if (done_seen) begin
                if (!done || cmd_valid)
                    check(1'b0, "R8", "done dropped or command after done",
                          {done, cmd_valid}, 2'b10);
            end
            prev_stall = cmd_valid && !cmd_ready;
            prev_op    = cmd_op;
            prev_data  = cmd_data;
        end
    end

    task automatic start_reset(input int n);
        @(posedge clk);
        #2;
        rst_n = 1'b0;
        dev_count = 5'(n);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        check(ctrl_rst_out && !cmd_valid && !done, "R1", "reset state",
              {ctrl_rst_out, cmd_valid, done}, 3'b100);
        push_expected(n);
        rst_cnt = 0; gap_cnt = 0; settle_cnt = 0; acc_cnt = 0;
        seen_cmd = 0; sw_seen = 0; done_seen = 0; prev_stall = 0;
        @(posedge clk);
        #2;
        rst_n = 1'b1;
    endtask

    task automatic run_case(input int n, input int n_late, input int mode, input string req);
        int t;
        rdy_mode = mode;
        start_reset(n);
        if (n_late != n) begin
            t = 0;
            while (!seen_cmd && t < 500) begin @(negedge clk); t++; end
            #1;
            dev_count = 5'(n_late);   // R11: change after capture
        end
        t = 0;
        while (!done && t < 3000) begin @(negedge clk); t++; end
        repeat (10) @(negedge clk);
        check(done, req, "done reached", done, 1);
        check(rst_cnt == HOLD, "R2", "reset hold cycles", rst_cnt, HOLD);
        check(gap_cnt == 1, "R3", "idle cycles before first command", gap_cnt, 1);
        check(settle_cnt == 1, "R7", "idle cycles before done", settle_cnt, 1);
        check(exp_q.size() == 0, req, "commands left unissued", exp_q.size(), 0);
    endtask

    initial begin
        #2_000_000;
        check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_cnt = 0; gap_cnt = 0; settle_cnt = 0; acc_cnt = 0;
        seen_cmd = 0; sw_seen = 0; done_seen = 0; prev_stall = 0;
        prev_op = '0; prev_data = '0;
        repeat (4) @(posedge clk);

        run_case(1, 1, 0, "R6");
        run_case(3, 3, 1, "R5");
        run_case(16, 16, 2, "R5");
        run_case(0, 0, 1, "R10");
        run_case(20, 20, 0, "R10");
        run_case(31, 31, 2, "R10");
        run_case(2, 9, 1, "R11");

        // R12: abandon a sequence mid-way, then rerun
        rdy_mode = 1;
        start_reset(5);
        begin
            int t = 0;
            while (acc_cnt < 3 && t < 2000) begin @(negedge clk); t++; end
        end
        check(!done && acc_cnt == 3, "R12", "mid-sequence point reached", acc_cnt, 3);
        run_case(4, 4, 0, "R12");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule